// File: doc/BRIEF.md
# Transmit Start and Collision Retry Controller

This block owns one outgoing frame from the moment software asks for it until the frame has gone out, been abandoned after repeated collisions, or been yielded to incoming traffic. Software programs where the frame sits in buffer memory (a 256-byte page number) and how many bytes it has. It then sets the transmit command bit. The controller then reads the frame, one byte per granted request, through a local DMA read port into an external transmit FIFO. It tells the serializer when it may start, which happens only once the medium has been quiet for the interframe gap, the FIFO holds data and any backoff wait is over.

When the serializer reports a collision, the controller flushes the FIFO, rewinds its read pointer and remaining count to the start of the frame, counts the collision and waits a random number of slot times. The range of that random draw doubles with each collision up to 1023 slots. After that wait it tries again. Once the collision limit is reached it abandons the frame. If carrier appears before the first byte has been fetched, it gives up the attempt and leaves the medium to the receive side.

Top module: `tx_start_ctrl`

## Requirements
- R1: A write of 1 to bit 0 at register index 3 while idle starts a transmission. On the next cycle `tx_busy` is 1, `tx_status` is 000, `coll_count` is 0, `fifo_flush` pulses in the command cycle, and `dma_addr` equals the page register shifted left by 8.
- R2: `dma_req` is high only while busy, while the remaining count is non-zero, while `fifo_full` and `rx_active` are low, and outside a collision cycle. Each cycle with `dma_req` and `dma_ack` both high advances `dma_addr` by one and lowers the remaining count by one. The count is loaded from index 1 (low byte) and index 2 (high byte).
- R3: Reads stop after the byte at address 0xFFFF even if bytes remain; the address never wraps to 0.
- R4: `tx_go` rises only in the cycle after one in which all of the following hold: the gap counter had reached GAP_CYCLES, `fifo_nonempty` was high, `carrier_sense` was low and the backoff counter was zero.
- R5: The gap counter returns to zero in every cycle with `carrier_sense` or `tx_go` high, and otherwise counts up by one per cycle until it reaches GAP_CYCLES, where it stays.
- R6: A cycle with `collision` and `tx_go` both high pulses `fifo_flush`. On the next cycle `tx_go` is low, `dma_addr` and the remaining count are back at their start values, `tx_status[1]` is set and `coll_count` has gone up by one.
- R7: After collision number n, the backoff lasts (L & (2^min(n,10) - 1)) × SLOT_CYCLES cycles. L is the value, in the collision cycle, of a 10-bit register reset to LFSR_SEED that steps every cycle to {L[8:0], L[9]^L[6]}.
- R8: The collision that brings the count to MAX_COLL (15) ends the attempt. On the next cycle `tx_status[2]` is set, `coll_count` reads 0 and `tx_busy` is low.
- R9: If `carrier_sense` is high while fetching and the FIFO is still empty, the attempt ends on the next cycle with `tx_busy` low and no status bit set.
- R10: `ser_done` during `tx_go` without a collision ends the frame. On the next cycle `tx_status[0]` is set, `tx_busy` is low and `tx_done` is high for exactly one cycle.
- R11: Writes to indices 0, 1 and 2 while busy are ignored, and a later start or rewind uses the values held before.
- R12: While `rx_active` is high, no DMA read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 page, 1 count low, 2 count high, 3 command |
| reg_wdata | input | 8 | Register write data |
| rx_active | input | 1 | Receive path busy; holds off prefetch |
| carrier_sense | input | 1 | Medium activity seen |
| collision | input | 1 | Collision reported by the serializer |
| dma_req | output | 1 | Local DMA read request |
| dma_addr | output | 16 | Byte address of the requested read |
| dma_ack | input | 1 | Read granted; byte goes into the FIFO this cycle |
| fifo_flush | output | 1 | Empty the transmit FIFO |
| fifo_nonempty | input | 1 | FIFO holds at least one byte |
| fifo_full | input | 1 | FIFO cannot take another byte |
| tx_go | output | 1 | Serializer may transmit (held for the whole attempt) |
| ser_done | input | 1 | Serializer finished the frame |
| tx_done | output | 1 | One-cycle frame completion pulse |
| tx_busy | output | 1 | Transmit command bit |
| tx_status | output | 3 | {aborted, collided, sent} |
| coll_count | output | 4 | Collisions in the current attempt |

## Verification
A wrong pointer or count shows on `dma_addr` or `dma_req` on the next granted read, or on the first cycle after a rewind. A timer that runs long or short moves the rising edge of `tx_go` by at least one cycle, and that edge is compared on every clock against a model that tracks the gap, the backoff and the random register. A bad collision or status count shows on `coll_count` and `tx_status` one cycle after the collision, and an abort decision taken at the wrong count shows as a wrong bit there at the fifteenth collision.

// File: rtl/tx_pkg.sv
// Shared definitions for the transmit start and retry controller.
// Assumes a byte-wide register interface with a 2-bit index.
package tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2
    } tx_state_e;

    localparam logic [1:0] IDX_PAGE  = 2'd0;
    localparam logic [1:0] IDX_CNTLO = 2'd1;
    localparam logic [1:0] IDX_CNTHI = 2'd2;
    localparam logic [1:0] IDX_CMD   = 2'd3;

    localparam int STAT_SENT = 0;
    localparam int STAT_COLL = 1;
    localparam int STAT_ABRT = 2;

    localparam int LFSR_W    = 10;
    localparam int MAX_EXP   = 10;
    localparam int MAX_SLOTS = 1023;
endpackage

// File: rtl/tx_gap_timer.sv
// Interframe gap timer. Counts quiet cycles and saturates at GAP_CYCLES.
// Assumes hold is high whenever the medium is busy or the block transmits.
module tx_gap_timer #(
    parameter int GAP_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic gap_ok
);
    localparam int W = $clog2(GAP_CYCLES + 1);
    localparam logic [W-1:0] GAP_V = W'(GAP_CYCLES);

    logic [W-1:0] cnt_q;

    // Restart on activity, otherwise count up to the gap length.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (hold)         cnt_q <= '0;
        else if (cnt_q != GAP_V) cnt_q <= cnt_q + 1'b1;
    end

    assign gap_ok = (cnt_q == GAP_V);

    p_gap_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= GAP_V);
    p_gap_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !gap_ok);
endmodule

// File: rtl/tx_backoff.sv
// Backoff timer with a free-running 10-bit LFSR for the random slot draw.
// Assumes coll_n is the collision count including the collision being loaded.
module tx_backoff #(
    parameter int          SLOT_CYCLES = 512,
    parameter logic [9:0]  LFSR_SEED   = 10'h2A5,
    parameter int          CW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] coll_n,
    output logic          done
);
    import tx_pkg::*;

    localparam int BW = $clog2(MAX_SLOTS * SLOT_CYCLES + 1);
    localparam logic [BW-1:0] CNT_MAX = BW'(MAX_SLOTS * SLOT_CYCLES);

    logic [LFSR_W-1:0] lfsr_q;
    logic [BW-1:0]     cnt_q;
    logic [3:0]        k;
    logic [LFSR_W-1:0] mask;
    logic [LFSR_W-1:0] slots;

    // Step the pseudo-random source every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= {lfsr_q[8:0], lfsr_q[9] ^ lfsr_q[6]};
    end

    // Truncate the exponent and mask the draw to the current range.
    always_comb begin
        if (int'(coll_n) > MAX_EXP) k = 4'(MAX_EXP);
        else                        k = 4'(coll_n);
        mask  = LFSR_W'((11'd1 << k) - 11'd1);
        slots = lfsr_q & mask;
    end

    // Load the wait on a collision, otherwise count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= BW'(slots) * BW'(SLOT_CYCLES);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    p_bo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q <= CNT_MAX);
endmodule

// File: rtl/tx_dma_ptr.sv
// Read pointer and remaining count for the frame fetch.
// Assumes load and step are never both high; load wins if they are.
module tx_dma_ptr #(
    parameter int AW = 16,
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   base,
    input  logic [CNTW-1:0] count,
    input  logic            step,
    output logic [AW-1:0]   addr,
    output logic            can_read
);
    logic [AW:0]     addr_q;
    logic [CNTW-1:0] rem_q;

    // Rewind to the frame start on load, else advance one byte per grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= {1'b0, base};
            rem_q  <= count;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    assign addr     = addr_q[AW-1:0];
    assign can_read = !addr_q[AW] && (rem_q != '0);

    p_no_step_past_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q[AW] |-> !step);
    p_no_step_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q == '0) |-> !step);
endmodule

// File: rtl/tx_start_ctrl.sv
// Transmit start and collision retry controller (top).
// Holds the page and count registers, sequences fetch, start, retry and abort,
// and reports status. Assumes the serializer holds collision/ser_done only
// while tx_go is high and that a FIFO byte lands on each dma_req && dma_ack.
module tx_start_ctrl #(
    parameter int         GAP_CYCLES  = 64,
    parameter int         SLOT_CYCLES = 512,
    parameter int         MAX_COLL    = 15,
    parameter logic [9:0] LFSR_SEED   = 10'h2A5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr_en,
    input  logic [1:0]                      reg_addr,
    input  logic [7:0]                      reg_wdata,
    input  logic                            rx_active,
    input  logic                            carrier_sense,
    input  logic                            collision,
    output logic                            dma_req,
    output logic [15:0]                     dma_addr,
    input  logic                            dma_ack,
    output logic                            fifo_flush,
    input  logic                            fifo_nonempty,
    input  logic                            fifo_full,
    output logic                            tx_go,
    input  logic                            ser_done,
    output logic                            tx_done,
    output logic                            tx_busy,
    output logic [2:0]                      tx_status,
    output logic [$clog2(MAX_COLL+1)-1:0]   coll_count
);
    import tx_pkg::*;

    localparam int CW = $clog2(MAX_COLL + 1);
    localparam logic [CW-1:0] COLL_LIM = CW'(MAX_COLL);

    tx_state_e     state_q;
    logic [7:0]    page_q;
    logic [15:0]   cnt_q;
    logic [CW-1:0] ncol_q;
    logic [2:0]    stat_q;
    logic          done_q;

    logic start_cmd, coll_hit, abort_now, give_up, go_now, sent_now;
    logic can_read, gap_ok, bo_done, step;
    logic [CW-1:0] ncol_next;

    // Decode the command and the events of this cycle.
    always_comb begin
        start_cmd = reg_wr_en && (reg_addr == IDX_CMD) && reg_wdata[0] && (state_q == ST_IDLE);
        coll_hit  = (state_q == ST_SEND) && collision;
        ncol_next = ncol_q + 1'b1;
        abort_now = coll_hit && (ncol_next == COLL_LIM);
        sent_now  = (state_q == ST_SEND) && ser_done && !collision;
        give_up   = (state_q == ST_FETCH) && carrier_sense && !fifo_nonempty;
        go_now    = (state_q == ST_FETCH) && !carrier_sense && gap_ok && fifo_nonempty && bo_done;
    end

    assign fifo_flush = start_cmd || coll_hit;
    assign dma_req    = (state_q != ST_IDLE) && can_read && !rx_active && !fifo_full && !coll_hit;
    assign step       = dma_req && dma_ack;

    // Frame location registers, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            cnt_q  <= '0;
        end else if (reg_wr_en && state_q == ST_IDLE) begin
            case (reg_addr)
                IDX_PAGE:  page_q      <= reg_wdata;
                IDX_CNTLO: cnt_q[7:0]  <= reg_wdata;
                IDX_CNTHI: cnt_q[15:8] <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // Attempt sequencing: idle, fetch and wait, transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:  if (start_cmd) state_q <= ST_FETCH;
                ST_FETCH: if (give_up) state_q <= ST_IDLE;
                          else if (go_now) state_q <= ST_SEND;
                ST_SEND:  if (coll_hit) state_q <= abort_now ? ST_IDLE : ST_FETCH;
                          else if (ser_done) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Status bits and collision count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            ncol_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= sent_now;
            if (start_cmd) begin
                stat_q <= '0;
                ncol_q <= '0;
            end else if (coll_hit) begin
                stat_q[STAT_COLL] <= 1'b1;
                if (abort_now) begin
                    stat_q[STAT_ABRT] <= 1'b1;
                    ncol_q            <= '0;
                end else begin
                    ncol_q <= ncol_next;
                end
            end else if (sent_now) begin
                stat_q[STAT_SENT] <= 1'b1;
            end
        end
    end

    tx_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (carrier_sense || state_q == ST_SEND),
        .gap_ok (gap_ok)
    );

    tx_backoff #(.SLOT_CYCLES(SLOT_CYCLES), .LFSR_SEED(LFSR_SEED), .CW(CW)) u_bo (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (coll_hit && !abort_now),
        .coll_n (ncol_next),
        .done   (bo_done)
    );

    tx_dma_ptr #(.AW(16), .CNTW(16)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_cmd || coll_hit),
        .base     ({page_q, 8'h00}),
        .count    (cnt_q),
        .step     (step),
        .addr     (dma_addr),
        .can_read (can_read)
    );

    assign tx_go      = (state_q == ST_SEND);
    assign tx_busy    = (state_q != ST_IDLE);
    assign tx_status  = stat_q;
    assign coll_count = ncol_q;
    assign tx_done    = done_q;

    p_cmd_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd |=> (tx_busy && tx_status == 3'b000 && coll_count == '0));
    p_go_conditions_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_go) |-> $past(fifo_nonempty && gap_ok && bo_done));
    p_rewind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        coll_hit |=> (dma_addr == {$past(page_q), 8'h00} && !tx_go));
    p_abort_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_status[STAT_ABRT]) |-> (coll_count == '0 && !tx_busy));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
    p_rx_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |-> !dma_req);
endmodule

// File: tb/tx_start_ctrl_tb.sv
// Bench: behavioural per-cycle reference model compared on every clock.
module tx_start_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GAP   = 8;
    localparam int SLOT  = 4;
    localparam int MAXC  = 15;
    localparam int DEPTH = 4;
    localparam logic [9:0] SEED = 10'h2A5;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n;
    logic reg_wr_en;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic rx_active, carrier_sense, collision, dma_ack, ser_done;
    logic fifo_nonempty, fifo_full;
    logic dma_req, fifo_flush, tx_go, tx_done, tx_busy;
    logic [15:0] dma_addr;
    logic [2:0] tx_status;
    logic [3:0] coll_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_start_ctrl #(.GAP_CYCLES(GAP), .SLOT_CYCLES(SLOT), .MAX_COLL(MAXC), .LFSR_SEED(SEED)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rx_active(rx_active), .carrier_sense(carrier_sense),
        .collision(collision), .dma_req(dma_req), .dma_addr(dma_addr), .dma_ack(dma_ack),
        .fifo_flush(fifo_flush), .fifo_nonempty(fifo_nonempty), .fifo_full(fifo_full),
        .tx_go(tx_go), .ser_done(ser_done), .tx_done(tx_done), .tx_busy(tx_busy),
        .tx_status(tx_status), .coll_count(coll_count)
    );

    // Stimulus variables, applied at each falling edge.
    int i_rst = 0, i_wr = 0, i_addr = 0, i_data = 0, i_rx = 0, i_cs = 0;
    int i_col = 0, i_ack = 1, i_done = 0;

    // Reference model state.
    int m_st, m_page, m_cnt, m_addr, m_rem, m_gap, m_bo, m_lfsr, m_ncol;
    int m_stat, m_done, m_lvl;
    int total = 0, bad = 0, cycles = 0;
    bit chk_en = 0, finished = 0;
    string cur_req = "R1";

    task automatic model_reset();
        m_st = 0; m_page = 0; m_cnt = 0; m_addr = 0; m_rem = 0; m_gap = 0;
        m_bo = 0; m_lfsr = SEED; m_ncol = 0; m_stat = 0; m_done = 0; m_lvl = 0;
    endtask

    task automatic cmp(string name, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, name, act, exp, $time);
        end
    endtask

    task automatic tick();
        int start, colh, abrt, sent, giveup, go, req, full, nonempty, k, slots;
        @(negedge clk);
        full = (m_lvl >= DEPTH); nonempty = (m_lvl > 0);
        rst_n = (i_rst != 0); reg_wr_en = (i_wr != 0); reg_addr = 2'(i_addr);
        reg_wdata = 8'(i_data); rx_active = (i_rx != 0); carrier_sense = (i_cs != 0);
        collision = (i_col != 0); dma_ack = (i_ack != 0); ser_done = (i_done != 0);
        fifo_full = (full != 0); fifo_nonempty = (nonempty != 0);
        #1;
        start  = i_wr && i_addr == 3 && (i_data & 1) && m_st == 0;
        colh   = (m_st == 2) && i_col;
        abrt   = colh && (m_ncol + 1 == MAXC);
        sent   = (m_st == 2) && i_done && !i_col;
        giveup = (m_st == 1) && i_cs && !nonempty;
        go     = (m_st == 1) && !i_cs && (m_gap == GAP) && nonempty && (m_bo == 0);
        req    = (m_st != 0) && (m_addr < 65536) && (m_rem != 0) && !i_rx && !full && !colh;
        if (chk_en) begin
            cmp("dma_req", dma_req, req);
            cmp("dma_addr", dma_addr, m_addr & 16'hFFFF);
            cmp("fifo_flush", fifo_flush, start || colh);
            cmp("tx_go", tx_go, m_st == 2);
            cmp("tx_busy", tx_busy, m_st != 0);
            cmp("tx_status", tx_status, m_stat);
            cmp("coll_count", coll_count, m_ncol);
            cmp("tx_done", tx_done, m_done);
        end
        // Advance the model across the coming rising edge.
        if (!i_rst) begin
            model_reset();
        end else begin
            if (i_cs || m_st == 2) m_gap = 0; else if (m_gap < GAP) m_gap++;
            k = (m_ncol + 1 < 10) ? m_ncol + 1 : 10;
            slots = m_lfsr & ((1 << k) - 1);
            if (colh && !abrt) m_bo = slots * SLOT; else if (m_bo > 0) m_bo--;
            m_lfsr = ((m_lfsr << 1) & 10'h3FF) | (((m_lfsr >> 9) ^ (m_lfsr >> 6)) & 1);
            if (start || colh) begin m_addr = m_page * 256; m_rem = m_cnt; end
            else if (req && i_ack) begin m_addr++; m_rem--; end
            if (start || colh) m_lvl = 0;
            else m_lvl = m_lvl + ((req && i_ack) ? 1 : 0) - ((m_st == 2 && m_lvl > 0) ? 1 : 0);
            if (i_wr && m_st == 0) begin
                if (i_addr == 0) m_page = i_data;
                else if (i_addr == 1) m_cnt = (m_cnt & 16'hFF00) | i_data;
                else if (i_addr == 2) m_cnt = (m_cnt & 16'h00FF) | (i_data << 8);
            end
            m_done = sent;
            if (start) begin m_stat = 0; m_ncol = 0; end
            else if (colh) begin
                m_stat |= 2;
                if (abrt) begin m_stat |= 4; m_ncol = 0; end else m_ncol++;
            end else if (sent) m_stat |= 1;
            case (m_st)
                0: if (start) m_st = 1;
                1: if (giveup) m_st = 0; else if (go) m_st = 2;
                2: if (colh) m_st = abrt ? 0 : 1; else if (i_done) m_st = 0;
                default: m_st = 0;
            endcase
        end
    endtask

    task automatic run(int n);
        for (int j = 0; j < n; j++) tick();
    endtask

    task automatic wr(int a, int d);
        i_wr = 1; i_addr = a; i_data = d; tick(); i_wr = 0;
    endtask

    task automatic wait_send(int limit);
        for (int j = 0; j < limit && m_st != 2; j++) tick();
    endtask

    task automatic finish_frame();
        i_done = 1; tick(); i_done = 0; run(3);
    endtask

    initial begin
        i_rst = 0; run(4);
        i_rst = 1; chk_en = 1;
        cur_req = "R1"; run(2);                 // reset state
        wr(0, 8'h12); wr(1, 5); wr(2, 0);
        wr(3, 1); run(1);                       // R1 start
        cur_req = "R11"; wr(0, 8'h77); wr(2, 8'h40);   // ignored while busy
        cur_req = "R4"; wait_send(100); run(4);
        cur_req = "R10"; finish_frame();
        // Collisions and backoff; page must still be 0x12 (R11).
        cur_req = "R6"; wr(3, 1); wait_send(100);
        i_col = 1; tick(); i_col = 0;
        cur_req = "R7";
        for (int c = 0; c < 3; c++) begin
            wait_send(6000); run(2); i_col = 1; tick(); i_col = 0;
        end
        wait_send(6000); finish_frame();
        // Excessive collisions.
        cur_req = "R8"; run(GAP); wr(3, 1);
        for (int c = 0; c < MAXC; c++) begin
            wait_send(6000); i_col = 1; tick(); i_col = 0;
        end
        run(4);
        // Receive side holds off the fetch.
        cur_req = "R12"; i_rx = 1; wr(3, 1); run(20); i_rx = 0;
        wait_send(100); finish_frame();
        // Carrier before any byte fetched.
        cur_req = "R9"; i_rx = 1; wr(3, 1); run(3);
        i_cs = 1; tick(); i_cs = 0; i_rx = 0; run(5);
        // Carrier with bytes fetched delays the start; grants are sparse.
        cur_req = "R5"; wr(3, 1); i_ack = 0; run(3);
        cur_req = "R2"; i_ack = 1; tick(); i_ack = 0; run(2); i_ack = 1;
        cur_req = "R5"; run(GAP + 2); i_cs = 1; run(3); i_cs = 0;
        wait_send(100); finish_frame();
        // Fetch at the top of the address space.
        cur_req = "R3"; run(GAP); wr(0, 8'hFF); wr(1, 0); wr(2, 3); wr(3, 1);
        wait_send(100); run(300); finish_frame();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1;
            bad++;
            $display("FAIL watchdog %s actual=%0d expected<%0d", cur_req, cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule